// File: doc/BRIEF.md
# Per-Core Watchdog Policy Register Bank

This block is a small memory-mapped register bank that holds the watchdog policy for a group of processor cores. Every core owns a slot of 0x20 bytes at `core * 0x20`. Each slot holds two words. The control/status word lets software pause that core's watchdog and arm a core reset on the watchdog's second timeout. The pointer word is read-only and reports where that core's watchdog registers live, together with a version number.

The pause state can only be entered by writing a magic byte code. It is left by writing 1 to the pause flag. The reset arm is set by writing 1 to its bit and is dropped by hardware whenever the core's power-active input is low. Both stored bits drive per-core outputs directly. The watchdog counters and the reset generator sit outside this block.

The bus is a plain single-port read/write interface:
- A write is taken on the rising edge where `we_i` is high.
- Read data is registered: `rdata_o` shows the word at the address sampled on the previous rising edge.

Top module: `wdt_ctrl_bank`

## Requirements
- R1: Core k's slot starts at byte address k*0x20. The control/status word is at slot offset 0x04 and the pointer word at slot offset 0x08. `rdata_o` presents the word addressed at the previous rising edge of `clk_i`.
- R2: A write to core k's control/status word with bits 7:0 equal to 0x76 sets core k's paused flag. Any other value in bits 7:0 leaves the flag unchanged.
- R3: A control/status write with bit 8 set clears the paused flag. Bit 8 at 0 leaves it unchanged. When one write carries both the 0x76 code and bit 8 set, the flag ends at 0.
- R4: A control/status write with bit 9 set sets the reset-arm flag. Bit 9 at 0 leaves it unchanged.
- R5: While `pwr_active_i[k]` is 0, core k's reset-arm flag is cleared on every clock edge. This clear wins over a write of 1 in the same cycle.
- R6: The pointer word of core k is read-only and reads as follows:
  - bits 20:0 read 0x78300 + 0x100*k;
  - bits 23:21 read version 0;
  - all other bits read 0;
  - writes to it have no effect.
- R7: The control/status word reads back as follows:
  - bit 8 returns the paused flag;
  - bit 9 returns the reset-arm flag;
  - bits 7:0 and 31:10 read 0.
- R8: Any address that is not a mapped word of an existing core reads 0, and writes to it change nothing. This includes slot offsets other than 0x04/0x08 and slots at or above the core count.
- R9: `pause_o[k]` and `rst_arm_o[k]` equal core k's stored flags. A write to one core's slot leaves every other core's flags unchanged.
- R10: Reset clears state as follows:
  - `rst_ni` low clears all flags and `rdata_o`;
  - `core_rst_ni[k]` low clears only core k's flags.
  - Both resets act asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Bank reset, active low, asynchronous |
| core_rst_ni | input | N_CORES | Per-core local reset of the stored flags, active low |
| pwr_active_i | input | N_CORES | Per-core power-active indication; 0 clears the reset arm |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write enable |
| rdata_o | output | 32 | Registered read data |
| pause_o | output | N_CORES | Per-core watchdog pause |
| rst_arm_o | output | N_CORES | Per-core second-timeout reset enable |

## Verification
The assertions assume the following about the inputs:
- `addr_i`, `we_i`, `wdata_i` and `pwr_active_i` are stable around each rising edge.
- The resets are the only asynchronous events.
- A write targets exactly one address.

The bench keeps to these assumptions as follows:
- It changes bus inputs and power-active levels only on falling edges.
- It toggles the reset inputs away from rising edges.
- It reads with `we_i` low, so read data never depends on a write landing in the same cycle.

// File: rtl/wdt_bank_pkg.sv
package wdt_bank_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned CODE_W   = 8;
  localparam int unsigned PAUSE_B  = 8;
  localparam int unsigned ARM_B    = 9;
  localparam int unsigned PTR_W    = 21;
  localparam int unsigned VER_W    = 3;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CS   = 2'd1,
    SEL_PTR  = 2'd2
  } word_sel_e;

  typedef struct packed {
    logic paused;
    logic arm;
  } slot_state_t;
endpackage

// File: rtl/wdt_addr_dec.sv
module wdt_addr_dec
  import wdt_bank_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned STRIDE  = 32,
  parameter int unsigned CS_OFS  = 4,
  parameter int unsigned PTR_OFS = 8,
  localparam int unsigned IDX_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int unsigned SLOT_LSB = $clog2(STRIDE)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output word_sel_e         sel_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [ADDR_W-1:0]   slot;
  logic [SLOT_LSB-1:0] ofs;
  logic                in_range;

  assign slot     = addr_i >> SLOT_LSB;
  assign ofs      = addr_i[SLOT_LSB-1:0];
  assign in_range = (slot < ADDR_W'(N_CORES));
  assign idx_o    = slot[IDX_W-1:0];

  always_comb begin
    sel_o = SEL_NONE;
    if (in_range) begin
      if (ofs == SLOT_LSB'(CS_OFS))       sel_o = SEL_CS;
      else if (ofs == SLOT_LSB'(PTR_OFS)) sel_o = SEL_PTR;
    end
  end
endmodule

// File: rtl/wdt_core_slot.sv
module wdt_core_slot
  import wdt_bank_pkg::*;
#(
  parameter logic [CODE_W-1:0] PAUSE_CODE = 8'h76
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pwr_active_i,
  output slot_state_t       state_o
);
  slot_state_t q, d;

  always_comb begin
    d = q;
    if (cs_we_i) begin
      // clear beats set when both arrive together
      if (wdata_i[PAUSE_B])                          d.paused = 1'b0;
      else if (wdata_i[CODE_W-1:0] == PAUSE_CODE)    d.paused = 1'b1;
      if (wdata_i[ARM_B])                            d.arm    = 1'b1;
    end
    if (!pwr_active_i) d.arm = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign state_o = q;
endmodule

// File: rtl/wdt_rd_mux.sv
module wdt_rd_mux
  import wdt_bank_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  parameter logic [PTR_W-1:0] PTR_BASE = 21'h78300,
  parameter logic [PTR_W-1:0] PTR_STEP = 21'h100,
  parameter logic [VER_W-1:0] VERSION  = 3'd0,
  localparam int unsigned IDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  word_sel_e          sel_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  slot_state_t        state_i [N_CORES],
  output logic [DATA_W-1:0]  rdata_o
);
  logic [DATA_W-1:0] rd_d;
  logic [PTR_W-1:0]  ptr_val;
  slot_state_t       cur;

  assign ptr_val = PTR_BASE + PTR_STEP * PTR_W'(idx_i);

  always_comb begin
    cur = '0;
    for (int k = 0; k < N_CORES; k++)
      if (idx_i == IDX_W'(k)) cur = state_i[k];
  end

  always_comb begin
    rd_d = '0;
    unique case (sel_i)
      SEL_CS: begin
        rd_d[PAUSE_B] = cur.paused;
        rd_d[ARM_B]   = cur.arm;
      end
      SEL_PTR: begin
        rd_d[PTR_W-1:0]           = ptr_val;
        rd_d[PTR_W+VER_W-1:PTR_W] = VERSION;
      end
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_d;
  end
endmodule

// File: rtl/wdt_ctrl_bank.sv
module wdt_ctrl_bank
  import wdt_bank_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned STRIDE  = 32,
  parameter int unsigned CS_OFS  = 4,
  parameter int unsigned PTR_OFS = 8,
  parameter logic [7:0]  PAUSE_CODE = 8'h76,
  parameter logic [20:0] PTR_BASE = 21'h78300,
  parameter logic [20:0] PTR_STEP = 21'h100,
  parameter logic [2:0]  VERSION  = 3'd0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_CORES-1:0] core_rst_ni,
  input  logic [N_CORES-1:0] pwr_active_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  input  logic               we_i,
  output logic [31:0]        rdata_o,
  output logic [N_CORES-1:0] pause_o,
  output logic [N_CORES-1:0] rst_arm_o
);
  localparam int unsigned IDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1;

  word_sel_e        sel;
  logic [IDX_W-1:0] idx;
  slot_state_t      state [N_CORES];

  wdt_addr_dec #(
    .N_CORES(N_CORES), .ADDR_W(ADDR_W), .STRIDE(STRIDE),
    .CS_OFS(CS_OFS), .PTR_OFS(PTR_OFS)
  ) i_dec (
    .addr_i(addr_i),
    .sel_o (sel),
    .idx_o (idx)
  );

  for (genvar k = 0; k < N_CORES; k++) begin : g_core
    logic cs_we;
    logic slot_rst_n;
    assign cs_we      = we_i && (sel == SEL_CS) && (idx == IDX_W'(k));
    assign slot_rst_n = rst_ni & core_rst_ni[k];

    wdt_core_slot #(.PAUSE_CODE(PAUSE_CODE)) i_slot (
      .clk_i       (clk_i),
      .rst_ni      (slot_rst_n),
      .cs_we_i     (cs_we),
      .wdata_i     (wdata_i),
      .pwr_active_i(pwr_active_i[k]),
      .state_o     (state[k])
    );

    assign pause_o[k]   = state[k].paused;
    assign rst_arm_o[k] = state[k].arm;
  end

  wdt_rd_mux #(
    .N_CORES(N_CORES), .PTR_BASE(PTR_BASE), .PTR_STEP(PTR_STEP), .VERSION(VERSION)
  ) i_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .idx_i  (idx),
    .state_i(state),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/wdt_bank_chk.sv
module wdt_bank_chk #(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned STRIDE  = 32,
  parameter int unsigned CS_OFS  = 4,
  parameter int unsigned PTR_OFS = 8,
  parameter logic [7:0]  PAUSE_CODE = 8'h76,
  parameter logic [20:0] PTR_BASE = 21'h78300,
  parameter logic [20:0] PTR_STEP = 21'h100,
  parameter logic [2:0]  VERSION  = 3'd0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_CORES-1:0] core_rst_ni,
  input logic [N_CORES-1:0] pwr_active_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [31:0]        wdata_i,
  input logic               we_i,
  input logic [31:0]        rdata_o,
  input logic [N_CORES-1:0] pause_o,
  input logic [N_CORES-1:0] rst_arm_o
);
  function automatic logic is_mapped(logic [ADDR_W-1:0] a);
    logic hit = 1'b0;
    for (int k = 0; k < N_CORES; k++)
      if (a == ADDR_W'(k*STRIDE + CS_OFS) || a == ADDR_W'(k*STRIDE + PTR_OFS)) hit = 1'b1;
    return hit;
  endfunction

  // R8
  unmapped_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_mapped(addr_i) |=> rdata_o == 32'h0);

  for (genvar k = 0; k < N_CORES; k++) begin : g_chk
    logic cs_wr;
    assign cs_wr = we_i && (addr_i == ADDR_W'(k*STRIDE + CS_OFS));

    // R2
    code_sets_pause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !core_rst_ni[k])
      cs_wr && wdata_i[7:0] == PAUSE_CODE && !wdata_i[8] |=> pause_o[k]);
    // R3
    clear_wins_pause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !core_rst_ni[k])
      cs_wr && wdata_i[8] |=> !pause_o[k]);
    // R9
    pause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !core_rst_ni[k])
      !cs_wr |=> $stable(pause_o[k]));
    // R4
    arm_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !core_rst_ni[k])
      cs_wr && wdata_i[9] && pwr_active_i[k] |=> rst_arm_o[k]);
    // R5
    pwr_clears_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !core_rst_ni[k])
      !pwr_active_i[k] |=> !rst_arm_o[k]);
    // R9
    arm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !core_rst_ni[k])
      !cs_wr && pwr_active_i[k] |=> $stable(rst_arm_o[k]));
    // R6
    ptr_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      addr_i == ADDR_W'(k*STRIDE + PTR_OFS) |=>
        rdata_o == {8'h0, VERSION, 21'(PTR_BASE + PTR_STEP * 21'(k))});
  end
endmodule

bind wdt_ctrl_bank wdt_bank_chk #(
  .N_CORES(N_CORES), .ADDR_W(ADDR_W), .STRIDE(STRIDE), .CS_OFS(CS_OFS),
  .PTR_OFS(PTR_OFS), .PAUSE_CODE(PAUSE_CODE), .PTR_BASE(PTR_BASE),
  .PTR_STEP(PTR_STEP), .VERSION(VERSION)
) i_wdt_bank_chk (.*);

// File: tb/test_wdt_ctrl_bank.sv
`timescale 1ns/100ps
module test_wdt_ctrl_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  core_rst_ni = 4'hF;
  logic [3:0]  pwr_active_i = 4'hF;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] rdata_o;
  logic [3:0]  pause_o, rst_arm_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  wdt_ctrl_bank i_wdt_ctrl_bank (.*);

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [3:0]  pwr;
    logic        chk;
    logic [31:0] rd;
    logic [3:0]  pz;
    logic [3:0]  arm;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h04, 32'h0,        4'hF, 1'b1, 32'h0,     4'h0, 4'h0, 8'd7}, // R7 idle read
    '{1'b1, 8'h24, 32'h75,       4'hF, 1'b0, 32'h0,     4'h0, 4'h0, 8'd2}, // R2 wrong code
    '{1'b1, 8'h24, 32'h76,       4'hF, 1'b0, 32'h0,     4'h2, 4'h0, 8'd2}, // R2 code sets
    '{1'b0, 8'h24, 32'h0,        4'hF, 1'b1, 32'h100,   4'h2, 4'h0, 8'd7}, // R7 readback
    '{1'b1, 8'h24, 32'h0,        4'hF, 1'b0, 32'h0,     4'h2, 4'h0, 8'd3}, // R3 zero keeps
    '{1'b1, 8'h44, 32'h176,      4'hF, 1'b0, 32'h0,     4'h2, 4'h0, 8'd3}, // R3 clear wins
    '{1'b1, 8'h24, 32'h100,      4'hF, 1'b0, 32'h0,     4'h0, 4'h0, 8'd3}, // R3 clear
    '{1'b1, 8'h64, 32'h200,      4'hF, 1'b0, 32'h0,     4'h0, 4'h8, 8'd4}, // R4 arm
    '{1'b1, 8'h64, 32'h76,       4'hF, 1'b0, 32'h0,     4'h8, 4'h8, 8'd4}, // R4 zero keeps arm
    '{1'b0, 8'h64, 32'h0,        4'hF, 1'b1, 32'h300,   4'h8, 4'h8, 8'd7}, // R7
    '{1'b0, 8'h00, 32'h0,        4'h7, 1'b1, 32'h0,     4'h8, 4'h0, 8'd5}, // R5 power drop
    '{1'b1, 8'h64, 32'h200,      4'h7, 1'b0, 32'h0,     4'h8, 4'h0, 8'd5}, // R5 clear beats set
    '{1'b1, 8'h64, 32'h200,      4'hF, 1'b0, 32'h0,     4'h8, 4'h8, 8'd4}, // R4 re-arm
    '{1'b0, 8'h08, 32'h0,        4'hF, 1'b1, 32'h78300, 4'h8, 4'h8, 8'd6}, // R6 core0
    '{1'b0, 8'h68, 32'h0,        4'hF, 1'b1, 32'h78600, 4'h8, 4'h8, 8'd6}, // R6 core3
    '{1'b1, 8'h48, 32'hFFFFFFFF, 4'hF, 1'b0, 32'h0,     4'h8, 4'h8, 8'd6}, // R6 write ignored
    '{1'b0, 8'h48, 32'h0,        4'hF, 1'b1, 32'h78500, 4'h8, 4'h8, 8'd6}, // R6 core2
    '{1'b1, 8'h84, 32'h376,      4'hF, 1'b0, 32'h0,     4'h8, 4'h8, 8'd8}, // R8 slot 4
    '{1'b0, 8'h84, 32'h0,        4'hF, 1'b1, 32'h0,     4'h8, 4'h8, 8'd8}, // R8 read
    '{1'b1, 8'h05, 32'h376,      4'hF, 1'b0, 32'h0,     4'h8, 4'h8, 8'd8}, // R8 odd offset
    '{1'b1, 8'h04, 32'h276,      4'hF, 1'b0, 32'h0,     4'h9, 4'h9, 8'd9}, // R9 core0 only
    '{1'b0, 8'h04, 32'h0,        4'hF, 1'b1, 32'h300,   4'h9, 4'h9, 8'd1}  // R1 slot0 cs
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check("R10 pause", 32'(pause_o), 32'h0);
    check("R10 arm", 32'(rst_arm_o), 32'h0);
    check("R10 rdata", rdata_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      we_i = VEC[i].we;
      addr_i = VEC[i].addr;
      wdata_i = VEC[i].wdata;
      pwr_active_i = VEC[i].pwr;
      @(negedge clk_i);
      checks++;
      if (pause_o !== VEC[i].pz || rst_arm_o !== VEC[i].arm ||
          (VEC[i].chk && rdata_o !== VEC[i].rd)) begin
        errors++;
        $display("FAIL R%0d vec %0d: actual pz=%h arm=%h rd=%h expected pz=%h arm=%h rd=%h",
                 VEC[i].req, i, pause_o, rst_arm_o, rdata_o, VEC[i].pz, VEC[i].arm, VEC[i].rd);
      end
    end
    we_i = 1'b0;
    addr_i = 8'h00;

    // R10 core-local reset only touches its own core
    core_rst_ni[0] = 1'b0;
    #1;
    check("R10 core reset pause", 32'(pause_o), 32'h8);
    check("R10 core reset arm", 32'(rst_arm_o), 32'h8);
    @(negedge clk_i);
    core_rst_ni[0] = 1'b1;
    @(negedge clk_i);
    check("R10 core0 stays clear", 32'(pause_o), 32'h8);

    // R1 read of core3 pointer word, one cycle after address
    addr_i = 8'h68;
    @(negedge clk_i);
    check("R1 registered read", rdata_o, 32'h78600);

    // R10 bank reset clears everything
    rst_ni = 1'b0;
    #1;
    check("R10 bank reset pause", 32'(pause_o), 32'h0);
    check("R10 bank reset arm", 32'(rst_arm_o), 32'h0);
    check("R10 bank reset rdata", rdata_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    finish_run();
  end
endmodule